// File: doc/BRIEF.md
# Multi-format serial line encoder

This block turns a stream of single bits into a line code on one transmit pin. Seven codes are available: plain NRZ, two NRZI variants, two biphase FM variants, Manchester and differential Manchester. They share one datapath. Time is set by a clock enable that pulses twice per bit period. The first pulse of each pair opens a bit cell and the second marks its middle, so codes that need a transition in mid-cell can produce one.

When a sender raises its valid signal while the line is idle, the encoder first sends a preamble whose pattern depends on the selected code. The preamble length is programmable and is held to the range 8 to 64 cells. Only after the preamble does the encoder offer ready, and it takes one bit per cell. If valid is low at the start of a data cell, the line falls back to idle, and the next valid starts a fresh preamble.

While idle, the line is either forced to a high level or fed with a constant one that is encoded like data. A global invert flips the final output in every code, and the flip is applied after the idle force.

Top module: `line_code_tx`

## Requirements
- R1: `codeSel` selects the code: 0 NRZ, 1 NRZI mark, 2 NRZI space, 3 FM0, 4 FM1, 5 Manchester, 6 differential Manchester. The value 7 behaves as NRZ. In NRZ the line holds the bit value for the whole cell.
- R2: NRZI mark inverts the line level at the cell start for a 1 and keeps it for a 0. NRZI space inverts it for a 0 and keeps it for a 1. The level carries over from cell to cell.
- R3: FM0 and FM1 invert the line at every cell start. FM0 adds a mid-cell inversion for a 0, and FM1 adds one for a 1.
- R4: Manchester sends high then low for a 1 and low then high for a 0. Differential Manchester always inverts at mid-cell, and inverts at the cell start only for a 0.
- R5: Preamble bits are 0 for NRZI mark and FM1, alternate 1,0,1,0 (starting with 1) for Manchester, and are 1 for NRZ, NRZI space, FM0 and differential Manchester.
- R6: The preamble length is `preambleLen` cells, with values below 8 treated as 8 and values above 64 treated as 64. `bitReady` is never high before the preamble has completed.
- R7: `bitReady` is high only in the cycle of a cell-start enable while the encoder is in the data phase. A bit is taken when `bitValid` and `bitReady` are both high. A data cell that starts with `bitValid` low becomes idle, and the next valid restarts the preamble.
- R8: In idle cells, `idleForceHigh`=1 holds the pre-invert line level at 1. `idleForceHigh`=0 encodes a constant 1 bit in the selected code.
- R9: `invertEn`=1 complements the output in every code, after the idle force has been applied, so a forced idle line reads 0.
- R10: `txd` is registered. It changes only in the cycle after a `halfEn` pulse: it takes the first-half level after a cell-start pulse and the second-half level after a mid-cell pulse. The first `halfEn` after reset opens a cell.
- R11: Reset drives `txd` to 1 and `bitReady` to 0, and leaves the encoder idle with a pre-invert line level of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| halfEn | input | 1 | Enable pulse at twice the bit rate |
| codeSel | input | 3 | Line code select |
| invertEn | input | 1 | Complement the output |
| idleForceHigh | input | 1 | Idle policy: 1 forces the line high, 0 encodes ones |
| preambleLen | input | 7 | Requested preamble length in cells |
| bitValid | input | 1 | A bit is offered |
| bitData | input | 1 | Offered bit value |
| bitReady | output | 1 | Bit accepted this cycle when valid |
| txd | output | 1 | Encoded line output |

## Verification
The hardest case to reach is the carry-over of line state between frames. NRZI and the FM codes depend on the level left by whatever came before, including idle cells that no check observes. The stimulus therefore starts each frame only after at least one forced-high idle cell, which puts the pre-invert level at a known 1. It then lets selected frames run on into several encoded idle cells that are compared half by half. Preamble clamping and the ready gate are checked by counting the cell starts that pass before the first ready, with requested lengths of 3, 20 and 100.

// File: rtl/line_code_pkg.sv
package line_code_pkg;

  localparam logic [2:0] CODE_NRZ        = 3'd0;
  localparam logic [2:0] CODE_NRZI_MARK  = 3'd1;
  localparam logic [2:0] CODE_NRZI_SPACE = 3'd2;
  localparam logic [2:0] CODE_FM0        = 3'd3;
  localparam logic [2:0] CODE_FM1        = 3'd4;
  localparam logic [2:0] CODE_MANCH      = 3'd5;
  localparam logic [2:0] CODE_DMANCH     = 3'd6;

  typedef enum logic [1:0] {
    CELL_IDLE = 2'd0,
    CELL_PRE  = 2'd1,
    CELL_DATA = 2'd2
  } cellKindE;

  // Strobes from the sequencer to the line datapath
  typedef struct packed {
    logic     cellStart;
    logic     cellMid;
    cellKindE kind;
    logic     dataBit;
    logic     preOdd;
  } strobeT;

endpackage

// File: rtl/line_code_ctrl.sv
module line_code_ctrl
  import line_code_pkg::*;
#(
  parameter int LEN_W   = 7,
  parameter int PRE_MIN = 8,
  parameter int PRE_MAX = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             halfEn,
  input  logic [LEN_W-1:0] preambleLen,
  input  logic             bitValid,
  input  logic             bitData,
  output logic             bitReady,
  output strobeT           stb
);

  localparam int CNT_W = $clog2(PRE_MAX + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_DATA} stateE;

  stateE            state, stateNext;
  logic             phase;
  logic [CNT_W-1:0] preCnt, preCntNext, preLast;
  cellKindE         curKind, kindNow;
  logic             preOddNow;
  logic             cellStart;

  assign cellStart = halfEn && !phase;

  // Clamp the requested length into the supported window
  always_comb begin
    if (preambleLen < LEN_W'(PRE_MIN))      preLast = CNT_W'(PRE_MIN - 1);
    else if (preambleLen > LEN_W'(PRE_MAX)) preLast = CNT_W'(PRE_MAX - 1);
    else                                    preLast = CNT_W'(preambleLen) - CNT_W'(1);
  end

  always_comb begin
    stateNext  = state;
    preCntNext = preCnt;
    kindNow    = curKind;
    preOddNow  = preCnt[0];
    bitReady   = 1'b0;
    if (cellStart) begin
      unique case (state)
        ST_IDLE: begin
          if (bitValid) begin
            kindNow    = CELL_PRE;
            preOddNow  = 1'b0;
            preCntNext = CNT_W'(1);
            stateNext  = ST_PRE;
          end else begin
            kindNow = CELL_IDLE;
          end
        end
        ST_PRE: begin
          kindNow = CELL_PRE;
          if (preCnt == preLast) stateNext = ST_DATA;
          else                   preCntNext = preCnt + CNT_W'(1);
        end
        ST_DATA: begin
          bitReady = 1'b1;
          if (bitValid) begin
            kindNow = CELL_DATA;
          end else begin
            kindNow   = CELL_IDLE;
            stateNext = ST_IDLE;
          end
        end
        default: begin
          kindNow   = CELL_IDLE;
          stateNext = ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      phase   <= 1'b0;
      preCnt  <= '0;
      curKind <= CELL_IDLE;
    end else if (halfEn) begin
      phase <= !phase;
      if (cellStart) begin
        state   <= stateNext;
        preCnt  <= preCntNext;
        curKind <= kindNow;
      end
    end
  end

  assign stb.cellStart = cellStart;
  assign stb.cellMid   = halfEn && phase;
  assign stb.kind      = kindNow;
  assign stb.dataBit   = bitData;
  assign stb.preOdd    = preOddNow;

endmodule

// File: rtl/line_code_dp.sv
module line_code_dp
  import line_code_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  strobeT     stb,
  input  logic [2:0] codeSel,
  input  logic       invertEn,
  input  logic       idleForceHigh,
  output logic       txd
);

  logic rawQ, holdQ, txdQ;
  logic preBit, cellBit, firstHalf, secondHalf;

  always_comb begin
    unique case (codeSel)
      CODE_NRZI_MARK, CODE_FM1: preBit = 1'b0;
      CODE_MANCH:               preBit = !stb.preOdd;
      default:                  preBit = 1'b1;
    endcase
    unique case (stb.kind)
      CELL_DATA: cellBit = stb.dataBit;
      CELL_PRE:  cellBit = preBit;
      default:   cellBit = 1'b1;
    endcase
  end

  // rawQ is the level left by the previous cell when a new cell opens
  always_comb begin
    unique case (codeSel)
      CODE_NRZI_MARK: begin
        firstHalf  = cellBit ? !rawQ : rawQ;
        secondHalf = firstHalf;
      end
      CODE_NRZI_SPACE: begin
        firstHalf  = cellBit ? rawQ : !rawQ;
        secondHalf = firstHalf;
      end
      CODE_FM0: begin
        firstHalf  = !rawQ;
        secondHalf = cellBit ? firstHalf : !firstHalf;
      end
      CODE_FM1: begin
        firstHalf  = !rawQ;
        secondHalf = cellBit ? !firstHalf : firstHalf;
      end
      CODE_MANCH: begin
        firstHalf  = cellBit;
        secondHalf = !cellBit;
      end
      CODE_DMANCH: begin
        firstHalf  = cellBit ? rawQ : !rawQ;
        secondHalf = !firstHalf;
      end
      default: begin
        firstHalf  = cellBit;
        secondHalf = cellBit;
      end
    endcase
    if (stb.kind == CELL_IDLE && idleForceHigh) begin
      firstHalf  = 1'b1;
      secondHalf = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rawQ  <= 1'b1;
      holdQ <= 1'b1;
      txdQ  <= 1'b1;
    end else if (stb.cellStart) begin
      rawQ  <= firstHalf;
      holdQ <= secondHalf;
      txdQ  <= firstHalf ^ invertEn;
    end else if (stb.cellMid) begin
      rawQ  <= holdQ;
      txdQ  <= holdQ ^ invertEn;
    end
  end

  assign txd = txdQ;

endmodule

// File: rtl/line_code_tx.sv
module line_code_tx
  import line_code_pkg::*;
#(
  parameter int LEN_W   = 7,
  parameter int PRE_MIN = 8,
  parameter int PRE_MAX = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             halfEn,
  input  logic [2:0]       codeSel,
  input  logic             invertEn,
  input  logic             idleForceHigh,
  input  logic [LEN_W-1:0] preambleLen,
  input  logic             bitValid,
  input  logic             bitData,
  output logic             bitReady,
  output logic             txd
);

  strobeT stb;

  line_code_ctrl #(
    .LEN_W  (LEN_W),
    .PRE_MIN(PRE_MIN),
    .PRE_MAX(PRE_MAX)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .halfEn     (halfEn),
    .preambleLen(preambleLen),
    .bitValid   (bitValid),
    .bitData    (bitData),
    .bitReady   (bitReady),
    .stb        (stb)
  );

  line_code_dp u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .codeSel      (codeSel),
    .invertEn     (invertEn),
    .idleForceHigh(idleForceHigh),
    .txd          (txd)
  );

endmodule

// File: rtl/line_code_tx_checker.sv
module line_code_tx_checker
  import line_code_pkg::*;
#(
  parameter int PRE_MIN = 8
) (
  input logic       clk,
  input logic       rstN,
  input logic       halfEn,
  input logic [2:0] codeSel,
  input logic       invertEn,
  input logic       idleForceHigh,
  input logic       bitReady,
  input logic       txd,
  input strobeT     stb
);

  logic       armed;
  logic [7:0] preSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed   <= 1'b0;
      preSeen <= '0;
    end else begin
      armed <= 1'b1;
      if (stb.cellStart) begin
        if (stb.kind == CELL_IDLE)                       preSeen <= '0;
        else if (stb.kind == CELL_PRE && preSeen != 8'hFF) preSeen <= preSeen + 8'd1;
      end
    end
  end

  // R10: the line moves only right after an enable pulse
  assert_txd_on_half_R10: assert property (@(posedge clk) disable iff (!rstN || !armed)
    !$past(halfEn) |-> $stable(txd));

  // R7: ready only together with an enable pulse
  assert_ready_with_half_R7: assert property (@(posedge clk) disable iff (!rstN)
    bitReady |-> halfEn);

  // R6: ready is withheld until the minimum preamble has gone out
  assert_ready_after_pre_R6: assert property (@(posedge clk) disable iff (!rstN)
    bitReady |-> (preSeen >= 8'(PRE_MIN)));

  // R9: a forced idle cell drives the complement of the invert control
  assert_force_idle_R9: assert property (@(posedge clk) disable iff (!rstN || !armed)
    (stb.cellStart && stb.kind == CELL_IDLE && idleForceHigh) |=> (txd == !$past(invertEn)));

  // R4: both Manchester codes always flip in mid-cell
  assert_mid_flip_R4: assert property (@(posedge clk) disable iff (!rstN || !armed)
    (stb.cellMid && stb.kind != CELL_IDLE &&
     (codeSel == CODE_MANCH || codeSel == CODE_DMANCH) &&
     $stable(codeSel) && $stable(invertEn)) |=> (txd != $past(txd)));

endmodule

bind line_code_tx line_code_tx_checker #(.PRE_MIN(PRE_MIN)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .halfEn       (halfEn),
  .codeSel      (codeSel),
  .invertEn     (invertEn),
  .idleForceHigh(idleForceHigh),
  .bitReady     (bitReady),
  .txd          (txd),
  .stb          (stb)
);

// File: tb/line_code_tx_bench.sv
module line_code_tx_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       halfEn = 1'b0;
  logic [2:0] codeSel = 3'd0;
  logic       invertEn = 1'b0;
  logic       idleForceHigh = 1'b1;
  logic [6:0] preambleLen = 7'd8;
  logic       bitValid = 1'b0;
  logic       bitData = 1'b0;
  logic       bitReady;
  logic       txd;

  int errors = 0;
  int checks = 0;

  logic  expLvl[$];
  string expTag[$];

  logic [1:0] divCnt = 2'd0;
  logic       curOdd = 1'b0;
  logic       nextOdd = 1'b0;

  always #10 clk = !clk;  // 50 MHz

  line_code_tx u_line_code_tx (
    .clk(clk), .rstN(rstN), .halfEn(halfEn), .codeSel(codeSel),
    .invertEn(invertEn), .idleForceHigh(idleForceHigh), .preambleLen(preambleLen),
    .bitValid(bitValid), .bitData(bitData), .bitReady(bitReady), .txd(txd)
  );

  // Enable generator: one pulse every four clocks; curOdd marks mid-cell pulses
  always @(negedge clk) begin
    if (!rstN) begin
      divCnt <= 2'd0; halfEn <= 1'b0; curOdd <= 1'b0; nextOdd <= 1'b0;
    end else begin
      divCnt <= divCnt + 2'd1;
      if (divCnt == 2'd3) begin
        halfEn <= 1'b1; curOdd <= nextOdd; nextOdd <= !nextOdd;
      end else begin
        halfEn <= 1'b0;
      end
    end
  end

  task automatic check(input logic ok, input string tag, input logic act, input logic expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, expv, $time);
    end
  endtask

  // Monitor (R10): each enable edge updates txd; compare one half-cell level per pulse
  initial begin
    forever begin
      @(posedge clk);
      if (rstN && halfEn && expLvl.size() > 0) begin
        logic  e;
        string t;
        e = expLvl.pop_front();
        t = expTag.pop_front();
        @(negedge clk);
        check(txd === e, t, txd, e);
      end
    end
  end

  // Reference cell encoder, written from the requirement text
  task automatic model_cell(input logic [2:0] code, input logic b, input logic frc,
                            inout logic lvl, output logic h1, output logic h2);
    case (code)
      3'd1: begin h1 = b ? ~lvl : lvl; h2 = h1; end
      3'd2: begin h1 = b ? lvl : ~lvl; h2 = h1; end
      3'd3: begin h1 = ~lvl; h2 = b ? h1 : ~h1; end
      3'd4: begin h1 = ~lvl; h2 = b ? ~h1 : h1; end
      3'd5: begin h1 = b; h2 = ~b; end
      3'd6: begin h1 = b ? lvl : ~lvl; h2 = ~h1; end
      default: begin h1 = b; h2 = b; end
    endcase
    if (frc) begin h1 = 1'b1; h2 = 1'b1; end
    lvl = h2;
  endtask

  function automatic logic pre_bit(input logic [2:0] code, input int idx);
    if (code == 3'd1 || code == 3'd4) return 1'b0;
    if (code == 3'd5) return (idx % 2 == 0);
    return 1'b1;
  endfunction

  task automatic push_cell(input logic [2:0] code, input logic b, input logic frc,
                           input logic inv, inout logic lvl, input string tag);
    logic h1, h2;
    model_cell(code, b, frc, lvl, h1, h2);
    expLvl.push_back(h1 ^ inv); expTag.push_back(tag);
    expLvl.push_back(h2 ^ inv); expTag.push_back(tag);
  endtask

  task automatic wait_mid();
    do begin @(negedge clk); #1; end while (!(halfEn && curOdd));
    @(posedge clk); #1;
  endtask

  task automatic send_frame(input logic [2:0] code, input logic inv, input logic frc,
                            input int lenIn, input int nBits, input logic [63:0] bits,
                            input int trail, input string tag);
    logic lvl;
    int   effLen;
    int   starts;
    while (expLvl.size() != 0) @(negedge clk);
    idleForceHigh = 1'b1;
    wait_mid();
    wait_mid();  // one forced idle cell has passed: level is 1
    effLen = (lenIn < 8) ? 8 : ((lenIn > 64) ? 64 : lenIn);
    lvl = 1'b1;
    for (int i = 0; i < effLen; i++) push_cell(code, pre_bit(code, i), 1'b0, inv, lvl, tag);
    for (int i = 0; i < nBits; i++) push_cell(code, bits[i], 1'b0, inv, lvl, tag);
    for (int i = 0; i < trail; i++) push_cell(code, 1'b1, frc, inv, lvl, tag);
    codeSel = code; invertEn = inv; idleForceHigh = frc;
    preambleLen = 7'(lenIn); bitData = bits[0]; bitValid = 1'b1;
    for (int k = 0; k < nBits; k++) begin
      starts = 0;
      forever begin
        @(negedge clk); #1;
        if (bitReady) break;
        if (halfEn && !curOdd) starts++;
      end
      if (k == 0) begin
        // R6 R7: ready first appears after exactly the clamped preamble length
        checks++;
        if (starts != effLen) begin
          errors++;
          $display("FAIL R6 preamble cells: actual=%0d expected=%0d", starts, effLen);
        end
      end
      @(posedge clk); #1;
      if (k < nBits - 1) bitData = bits[k+1];
      else bitValid = 1'b0;
    end
    while (expLvl.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset values
    check(txd === 1'b1, "R11 txd", txd, 1'b1);
    check(bitReady === 1'b0, "R11 ready", bitReady, 1'b0);
    @(negedge clk); rstN = 1'b1;

    send_frame(3'd0, 1'b0, 1'b1, 8,  8, 64'hB5, 1, "R1 NRZ");
    send_frame(3'd1, 1'b0, 1'b1, 8,  8, 64'h6C, 1, "R2 NRZI mark");
    send_frame(3'd2, 1'b0, 1'b1, 9,  8, 64'h6C, 1, "R2 NRZI space");
    send_frame(3'd3, 1'b0, 1'b1, 20, 8, 64'hA3, 1, "R3 FM0");
    send_frame(3'd4, 1'b0, 1'b1, 8,  8, 64'hA3, 1, "R3 FM1");
    send_frame(3'd5, 1'b0, 1'b1, 11, 8, 64'h4E, 1, "R4 R5 Manchester");
    send_frame(3'd6, 1'b0, 1'b1, 8,  8, 64'h4E, 1, "R4 R5 diff Manchester");
    send_frame(3'd7, 1'b0, 1'b1, 8,  6, 64'h29, 1, "R1 code 7");
    send_frame(3'd4, 1'b0, 1'b1, 3,  4, 64'h9,  1, "R6 short length");
    send_frame(3'd0, 1'b0, 1'b1, 100, 5, 64'h15, 1, "R6 long length");
    send_frame(3'd0, 1'b1, 1'b1, 8,  8, 64'hB5, 2, "R9 invert NRZ");
    send_frame(3'd3, 1'b1, 1'b1, 8,  6, 64'h2D, 2, "R9 invert FM0");
    send_frame(3'd1, 1'b0, 1'b0, 8,  5, 64'h13, 4, "R8 encoded idle");
    send_frame(3'd6, 1'b1, 1'b0, 8,  5, 64'h0A, 4, "R8 R9 encoded idle inverted");
    send_frame(3'd2, 1'b0, 1'b1, 8,  3, 64'h5,  1, "R7 restart");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule